// File: doc/BRIEF.md
# Precision Time-of-Day Counter

The block keeps a running wall-clock time for precision time protocol timestamping and presents it as a 96-bit value on every clock cycle. The time is held as three fields: whole seconds, nanoseconds within the second, and a binary fraction of a nanosecond. On every cycle a programmable period, given in whole and fractional nanoseconds, is added to the time. The nanoseconds field wraps at one billion, and each wrap carries one into the seconds field.

Software drives the block through a plain write port and has three ways to steer the time. A coarse load overwrites the time outright. A write to the normal period changes the rate, which is how a servo trims frequency. An offset correction makes the block use a second period for a chosen number of cycles, which removes a phase error without a jump in the time. Any of these may be repeated at any point while the counter runs, so drift can be corrected periodically. A load whose nanoseconds value is out of range is refused, and a sticky flag records the refusal until software clears it.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the timestamp is all zero, the error flag is low, no offset correction is pending, and the normal period is 6.4 ns (whole 6, fraction 0x6666).
- R2: When no load occurs, each clock edge adds the period in use to the time. The fractional sum carries into nanoseconds, and the nanoseconds sum carries into seconds.
- R3: The nanoseconds field never reaches 1,000,000,000. When nanoseconds plus the increment reaches that value, it is reduced by 1,000,000,000 and seconds rises by one on the same edge. Seconds wrap from all ones to zero.
- R4: A write to address 0 sets the normal period: data[19:16] are whole nanoseconds and data[15:0] are the fraction in units of 2^-16 ns. The edge that accepts the write still uses the old value, and the new value applies from the next edge.
- R5: A write to address 1 sets the correction period, in the same format as R4. A write of N to address 2 (data[19:0]) starts a correction. On each of the next N edges the correction period replaces the normal period. After that the normal period applies again.
- R6: Address 3 stages seconds bits 31:0 from data[31:0], and address 4 stages seconds bits 47:32 from data[15:0]. A write of a legal nanoseconds value to address 5 loads the staged seconds and that nanoseconds value, with the fraction at zero. The loaded time shows on the output after the write edge, and the increment is skipped on that edge.
- R7: A write to address 5 with a value of 1,000,000,000 or more leaves the time running as if there were no write and sets the error flag. The flag stays high until it is cleared.
- R8: Any write to address 6 clears the error flag after that edge.
- R9: The output carries seconds in bits 95:48, nanoseconds in bits 47:16, and the fraction in bits 15:0.
- R10: A write to address 2 while a correction is running restarts the count at the new value. It does not add to the cycles left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| tod_out | output | 96 | Current time {seconds, nanoseconds, fraction} |
| load_err | output | 1 | Sticky flag for a refused time load |

## Verification
The time accumulates, so any error in the internal state shows on tod_out on the edge that follows it and then stays there. A wrong fraction, period or correction count shows as a wrong step size within one cycle. A correction count that is off by one moves the time by exactly one period difference from the edge where the correction should have ended. The reference model tracks the time as a single integer of fractional nanoseconds within the second and is compared on every cycle. A bad carry or wrap is therefore reported on the first edge where it happens. The tests of seconds rollover and of refused loads are built around the exact cycle of the wrap or the write.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

  parameter int SEC_W    = 48;
  parameter int NS_W     = 32;
  parameter int FRAC_W   = 16;
  parameter int PINT_W   = 4;
  parameter int CNT_W    = 20;
  parameter int ADDR_W   = 3;
  parameter int DATA_W   = 32;
  parameter int unsigned NS_PER_SEC = 1000000000;
  parameter int RST_PER_WHOLE = 6;
  parameter int RST_PER_FRAC  = 16'h6666;

  localparam int TOD_W = SEC_W + NS_W + FRAC_W;
  localparam int PER_W = PINT_W + FRAC_W;
  localparam logic [NS_W:0] NS_ROLL = (NS_W + 1)'(NS_PER_SEC);

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } tod_t;

  typedef struct packed {
    logic [PINT_W-1:0] whole;
    logic [FRAC_W-1:0] frac;
  } period_t;

  typedef struct packed {
    logic wrap;
    tod_t t;
  } step_res_t;

  typedef enum logic [ADDR_W-1:0] {
    RA_PERIOD  = 3'd0,
    RA_ADJ_PER = 3'd1,
    RA_ADJ_CNT = 3'd2,
    RA_SEC_LO  = 3'd3,
    RA_SEC_HI  = 3'd4,
    RA_NS_LOAD = 3'd5,
    RA_ERR_CLR = 3'd6
  } reg_addr_e;

  localparam period_t RST_PERIOD = '{whole: PINT_W'(RST_PER_WHOLE),
                                     frac:  FRAC_W'(RST_PER_FRAC)};

  // Advance a time value by one period; reports the nanosecond wrap.
  function automatic step_res_t tod_advance(input tod_t t, input period_t p);
    logic [FRAC_W:0] fsum;
    logic [NS_W:0]   nsum;
    step_res_t       r;
    fsum = {1'b0, t.frac} + {1'b0, p.frac};
    nsum = {1'b0, t.ns} + (NS_W + 1)'(p.whole) + (NS_W + 1)'(fsum[FRAC_W]);
    r.t.frac = fsum[FRAC_W-1:0];
    if (nsum >= NS_ROLL) begin
      r.wrap   = 1'b1;
      r.t.ns   = NS_W'(nsum - NS_ROLL);
      r.t.sec  = t.sec + SEC_W'(1);
    end else begin
      r.wrap   = 1'b0;
      r.t.ns   = nsum[NS_W-1:0];
      r.t.sec  = t.sec;
    end
    return r;
  endfunction

  // A nanoseconds load value is legal when below one second.
  function automatic logic ns_is_legal(input logic [DATA_W-1:0] v);
    return ({1'b0, v} < (DATA_W + 1)'(NS_PER_SEC));
  endfunction

  function automatic period_t period_from_word(input logic [DATA_W-1:0] v);
    period_t p;
    p.whole = v[PER_W-1:FRAC_W];
    p.frac  = v[FRAC_W-1:0];
    return p;
  endfunction

endpackage

// File: rtl/ptpc_regif.sv
module ptpc_regif
  import ptpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output period_t           norm_period,
  output period_t           adj_period,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              load_req,
  output logic              load_bad,
  output logic              err_clr,
  output tod_t              load_val,
  output logic              err_flag
);

  localparam int SEC_HI_W = SEC_W - DATA_W;

  logic [SEC_W-1:0] sec_stage;
  logic             hit_period, hit_adj, hit_ns;

  assign hit_period = wr_en && (wr_addr == RA_PERIOD);
  assign hit_adj    = wr_en && (wr_addr == RA_ADJ_PER);
  assign hit_ns     = wr_en && (wr_addr == RA_NS_LOAD);
  assign cnt_wr     = wr_en && (wr_addr == RA_ADJ_CNT);
  assign err_clr    = wr_en && (wr_addr == RA_ERR_CLR);
  assign cnt_val    = wr_data[CNT_W-1:0];
  assign load_req   = hit_ns && ns_is_legal(wr_data);
  assign load_bad   = hit_ns && !ns_is_legal(wr_data);

  assign load_val.sec  = sec_stage;
  assign load_val.ns   = NS_W'(wr_data);
  assign load_val.frac = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_period <= RST_PERIOD;
      adj_period  <= RST_PERIOD;
    end else begin
      if (hit_period) norm_period <= period_from_word(wr_data);
      if (hit_adj)    adj_period  <= period_from_word(wr_data);
    end
  end

  generate
    if (SEC_HI_W > 0) begin : g_split_sec
      logic hit_lo, hit_hi;
      assign hit_lo = wr_en && (wr_addr == RA_SEC_LO);
      assign hit_hi = wr_en && (wr_addr == RA_SEC_HI);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sec_stage <= '0;
        end else begin
          if (hit_lo) sec_stage[DATA_W-1:0]     <= wr_data;
          if (hit_hi) sec_stage[SEC_W-1:DATA_W] <= wr_data[SEC_HI_W-1:0];
        end
      end
    end else begin : g_single_sec
      logic hit_lo;
      assign hit_lo = wr_en && (wr_addr == RA_SEC_LO);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sec_stage <= '0;
        else if (hit_lo) sec_stage <= wr_data[SEC_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_flag <= 1'b0;
    else if (load_bad) err_flag <= 1'b1;
    else if (err_clr)  err_flag <= 1'b0;
  end

endmodule

// File: rtl/ptpc_period_sel.sv
module ptpc_period_sel
  import ptpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  period_t          norm_period,
  input  period_t          adj_period,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output period_t          eff_period,
  output logic             adj_active,
  output logic [CNT_W-1:0] adj_cnt
);

  assign adj_active = (adj_cnt != '0);
  assign eff_period = adj_active ? adj_period : norm_period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          adj_cnt <= '0;
    else if (cnt_wr)     adj_cnt <= cnt_val;
    else if (adj_active) adj_cnt <= adj_cnt - CNT_W'(1);
  end

endmodule

// File: rtl/ptpc_time_acc.sv
module ptpc_time_acc
  import ptpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  period_t eff_period,
  input  logic    load_req,
  input  tod_t    load_val,
  output tod_t    tod_q,
  output logic    ns_wrap
);

  step_res_t step;

  assign step    = tod_advance(tod_q, eff_period);
  assign ns_wrap = !load_req && step.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tod_q <= '0;
    else if (load_req) tod_q <= load_val;
    else               tod_q <= step.t;
  end

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TOD_W-1:0]  tod_out,
  output logic              load_err
);

  period_t          norm_period, adj_period, eff_period;
  logic             cnt_wr, load_req, load_bad, err_clr, err_flag;
  logic             adj_active, ns_wrap;
  logic [CNT_W-1:0] cnt_val, adj_cnt;
  tod_t             load_val, tod_q;

  ptpc_regif regif_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .norm_period (norm_period),
    .adj_period  (adj_period),
    .cnt_wr      (cnt_wr),
    .cnt_val     (cnt_val),
    .load_req    (load_req),
    .load_bad    (load_bad),
    .err_clr     (err_clr),
    .load_val    (load_val),
    .err_flag    (err_flag)
  );

  ptpc_period_sel psel_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .norm_period (norm_period),
    .adj_period  (adj_period),
    .cnt_wr      (cnt_wr),
    .cnt_val     (cnt_val),
    .eff_period  (eff_period),
    .adj_active  (adj_active),
    .adj_cnt     (adj_cnt)
  );

  ptpc_time_acc acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_period (eff_period),
    .load_req   (load_req),
    .load_val   (load_val),
    .tod_q      (tod_q),
    .ns_wrap    (ns_wrap)
  );

  assign tod_out  = tod_q;
  assign load_err = err_flag;

endmodule

// File: rtl/ptpc_chk.sv
module ptpc_chk
  import ptpc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input tod_t             tod_q,
  input logic             load_err,
  input logic             load_req,
  input logic             load_bad,
  input logic             err_clr,
  input tod_t             load_val,
  input logic             ns_wrap,
  input logic             adj_active,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] adj_cnt
);

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, tod_q.ns} < NS_ROLL);

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> tod_q.sec == SEC_W'($past(tod_q.sec) + SEC_W'($past(ns_wrap))));

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (tod_q == $past(load_val)) && (tod_q.frac == '0));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_bad |=> load_err);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_err && !err_clr) |=> load_err);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !load_err);

  // R5
  adj_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_active && !cnt_wr) |=> adj_cnt == $past(adj_cnt) - CNT_W'(1));

  // R5
  adj_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_active && !cnt_wr) |=> !adj_active);

endmodule

bind ptp_tod_counter ptpc_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tod_q      (tod_q),
  .load_err   (load_err),
  .load_req   (load_req),
  .load_bad   (load_bad),
  .err_clr    (err_clr),
  .load_val   (load_val),
  .ns_wrap    (ns_wrap),
  .adj_active (adj_active),
  .cnt_wr     (cnt_wr),
  .adj_cnt    (adj_cnt)
);

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [95:0] tod_out;
  logic        load_err;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string phase = "R1";

  // Reference model state: time within the second kept in 2^-16 ns units.
  longint m_sec = 0, m_sub = 0, m_stage = 0;
  longint m_per = 64'h66666, m_adj = 64'h66666, m_cnt = 0;
  bit     m_err = 0;
  localparam longint ROLL = 64'd1000000000 * 64'd65536;
  localparam longint SMASK = 64'h0000_FFFF_FFFF_FFFF;

  always #10 clk = ~clk;

  ptp_tod_counter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tod_out  (tod_out),
    .load_err (load_err)
  );

  always @(posedge clk) begin
    longint stp;
    bit     legal;
    if (!rst_n) begin
      m_sec = 0; m_sub = 0; m_stage = 0; m_per = 64'h66666;
      m_adj = 64'h66666; m_cnt = 0; m_err = 0;
    end else begin
      stp = (m_cnt != 0) ? m_adj : m_per;
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      legal = (longint'(wr_data) < 64'd1000000000);
      if (wr_en && wr_addr == 3'd5 && legal) begin
        m_sec = m_stage;
        m_sub = longint'(wr_data) * 65536;
      end else begin
        m_sub = m_sub + stp;
        if (m_sub >= ROLL) begin
          m_sub = m_sub - ROLL;
          m_sec = (m_sec + 1) & SMASK;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_per = longint'(wr_data[19:0]);
          3'd1: m_adj = longint'(wr_data[19:0]);
          3'd2: m_cnt = longint'(wr_data[19:0]);
          3'd3: m_stage = (m_stage & 64'hFFFF_0000_0000) | longint'(wr_data);
          3'd4: m_stage = (m_stage & 64'hFFFF_FFFF) | (longint'(wr_data[15:0]) << 32);
          3'd5: if (!legal) m_err = 1;
          3'd6: m_err = 0;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    logic [47:0] es;
    logic [31:0] en;
    logic [15:0] ef;
    bit          bad;
    if (rst_n && !done) begin
      es = m_sec[47:0];
      en = 32'(m_sub >>> 16);
      ef = m_sub[15:0];
      bad = 0;
      checks++;
      if (tod_out[95:48] !== es) begin
        $display("FAIL %s seconds act=%h exp=%h", phase, tod_out[95:48], es); bad = 1;
      end
      if (tod_out[47:16] !== en) begin
        $display("FAIL %s nanoseconds act=%0d exp=%0d", phase, tod_out[47:16], en); bad = 1;
      end
      if (tod_out[15:0] !== ef) begin
        $display("FAIL %s fraction act=%h exp=%h", phase, tod_out[15:0], ef); bad = 1;
      end
      if (load_err !== m_err) begin
        $display("FAIL %s error flag act=%0b exp=%0b", phase, load_err, m_err); bad = 1;
      end
      if (bad) failures++;
    end
  end

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic longint sub_of(input logic [95:0] t);
    return longint'(t[47:16]) * 65536 + longint'(t[15:0]);
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint a, b;
    idle(3);
    // R1: reset state
    chk("R1 tod at reset", tod_out, 96'h0);
    chk("R1 err at reset", {95'h0, load_err}, 96'h0);
    rst_n = 1'b1;
    idle(1);
    // R1: first step is the nominal 6.4 ns
    chk("R1 first step", tod_out, {48'h0, 32'd6, 16'h6666});
    phase = "R2";
    idle(30);

    // R4: new period applies from the edge after the write
    phase = "R4";
    wr(3'd0, 32'h0008_0000);
    a = sub_of(tod_out);
    idle(1);
    b = sub_of(tod_out);
    chk("R4 step after period write", 96'(b - a), 96'(64'd8 * 65536));

    // R5: correction of 10 cycles at 2.5 ns
    phase = "R5";
    wr(3'd1, 32'h0002_8000);
    wr(3'd2, 32'd10);
    a = sub_of(tod_out);
    idle(10);
    b = sub_of(tod_out);
    chk("R5 ten corrected steps", 96'(b - a), 96'(64'd25 * 65536));
    idle(1);
    a = sub_of(tod_out);
    chk("R5 normal period resumes", 96'(a - b), 96'(64'd8 * 65536));
    idle(5);

    // R10: a count write restarts the count
    phase = "R10";
    wr(3'd2, 32'd50);
    idle(5);
    wr(3'd2, 32'd3);
    a = sub_of(tod_out);
    idle(3);
    b = sub_of(tod_out);
    chk("R10 restarted count ends", 96'(b - a), 96'(64'd75 * 32768 * 2 / 10));
    idle(1);
    a = sub_of(tod_out);
    chk("R10 normal after restart", 96'(a - b), 96'(64'd8 * 65536));

    // R6 / R9: coarse load
    phase = "R6";
    wr(3'd3, 32'h2345_6789);
    wr(3'd4, 32'h0000_0001);
    wr(3'd5, 32'd999999995);
    chk("R6 loaded time", tod_out, {48'h0001_2345_6789, 32'd999999995, 16'h0});
    chk("R9 seconds field position", {48'h0, tod_out[95:48]}, {48'h0, 48'h0001_2345_6789});
    // R3: nanosecond wrap carries into seconds
    idle(1);
    chk("R3 ns wrap", tod_out, {48'h0001_2345_678A, 32'd3, 16'h0});
    phase = "R3";
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0000_FFFF);
    wr(3'd5, 32'd999999999);
    idle(1);
    chk("R3 seconds rollover", tod_out, {48'h0, 32'd7, 16'h0});
    idle(4);

    // R7: refused loads
    phase = "R7";
    a = sub_of(tod_out);
    wr(3'd5, 32'd1000000000);
    b = sub_of(tod_out);
    chk("R7 time keeps running", 96'(b - a), 96'(64'd8 * 65536));
    chk("R7 flag set", {95'h0, load_err}, 96'h1);
    wr(3'd5, 32'hFFFF_FFFF);
    idle(4);
    chk("R7 flag sticky", {95'h0, load_err}, 96'h1);

    // R8: clear
    phase = "R8";
    wr(3'd6, 32'h0);
    chk("R8 flag cleared", {95'h0, load_err}, 96'h0);
    idle(2);

    // R2: back to nominal and run with fractional carries
    phase = "R2";
    wr(3'd0, 32'h0006_6666);
    idle(120);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule